// File: doc/BRIEF.md
# DRAM Cycle Sequencer and Arbiter

This block decides, cycle by cycle, whether the DRAM array serves a processor access or a refresh, and produces the strobes for that cycle. It uses both edges of one clock. A pending access request (active low) is looked at on rising edges. A pending refresh request (active high, supplied by a separate refresh-request counter) is looked at on falling edges. Whichever is seen first after the RAS precharge window has closed gets the array. The loser waits until that cycle and its precharge are over.

For an access cycle, the block raises a grant and drops RAS together. It later steers the external address multiplexer from row to column and drops CAS. It then drives an active-low acknowledge whose output enable follows the request. A refresh cycle keeps the grant low and points the multiplexer at the refresh address. It drops RAS half a clock later for a fixed four-cycle pulse and reports completion with a one-cycle pulse.

Three static inputs tune the timing: precharge length, row-address hold length, and page mode. In page mode, RAS is held past four cycles for as long as both the page and request inputs stay low.

Top module: `dram_seq`

## Requirements
- R1: After synchronous reset, ras_n, cas_n and ack_n are high, grant and refresh_done are low, addr_sel is 0, and the precharge window counts as already satisfied, so a request can start at once.
- R2: An access begins at the rising edge where req_n is sampled low while the sequencer is idle and precharge is satisfied. grant rises and ras_n falls at that same edge, and addr_sel shows the row (0).
- R3: Between the rise of ras_n and its next fall, ras_n stays high for at least 4 clock cycles when prech_n is low and at least 3 when prech_n is high.
- R4: A refresh request sampled high at a falling edge, while idle and with precharge satisfied, wins over an access not yet taken. addr_sel becomes 2 (refresh) at that falling edge and ras_n falls at the next rising edge. grant stays low for the whole refresh. A request that loses is served after the cycle and its precharge.
- R5: A refresh holds ras_n low for exactly 4 cycles, whatever page_n is. refresh_done is high for exactly one cycle, starting at the rising edge where ras_n rises.
- R6: In an access, addr_sel switches from row (0) to column (1) half a cycle after ras_n falls (falling edge) when hold_n is high, and one cycle after it (rising edge) when hold_n is low.
- R7: cas_n falls 1.5 cycles after ras_n falls in every access, independent of hold_n. It rises at the falling edge that follows the rising edge where req_n is sampled high.
- R8: With page_n high, access ras_n is low for exactly 4 cycles. With page_n low, ras_n stays low until the first rising edge, at or after 4 cycles, that samples page_n or req_n high.
- R9: ack_oe equals the inverse of req_n at all times. ack_n falls at the rising edge 4 cycles after ras_n fell if req_n is still low, and rises at the rising edge that samples req_n high.
- R10: After an access completes, grant, cas_n, ack_n and addr_sel keep their values until req_n is sampled high. At that edge grant, ack_n and addr_sel return to idle. A request released before 4 cycles drops grant and CAS at once but still completes the 4-cycle RAS pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges used |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 1 | Access request, active low, sampled on rising edges |
| page_n | input | 1 | Page mode select, active low |
| prech_n | input | 1 | Precharge length select: low = 4 cycles, high = 3 |
| hold_n | input | 1 | Row hold select: low = full cycle, high = half cycle |
| refresh_req | input | 1 | Refresh pending, active high, sampled on falling edges |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| grant | output | 1 | Access cycle granted, active high |
| ack_n | output | 1 | Acknowledge data bit, active low |
| ack_oe | output | 1 | Acknowledge output enable |
| addr_sel | output | 2 | Address mux select: 0 row, 1 column, 2 refresh |
| refresh_done | output | 1 | One-cycle pulse when a refresh RAS pulse ends |

## Verification
Some internal faults show within one cycle at the ports. A stuck or mis-counted precharge counter moves the next ras_n fall by whole cycles, so the earliest following request or refresh shows it. A wrong RAS-length counter shifts the ras_n rise, the ack_n fall and refresh_done together, four cycles after the cycle starts. A corrupted falling-edge stage is visible half a cycle later as a wrong addr_sel or cas_n level, and it can hand the array to the wrong requester on a tie. Because of this, the reference model is compared after every edge rather than once per cycle.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_HOLD = 2'd2,
    ST_REF  = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    SEL_ROW = 2'd0,
    SEL_COL = 2'd1,
    SEL_REF = 2'd2
  } addr_sel_e;

  // Cycles of RAS-high required before the next RAS fall.
  function automatic int unsigned prech_need(input logic prech_n,
                                             input int unsigned short_c,
                                             input int unsigned long_c);
    return prech_n ? short_c : long_c;
  endfunction

endpackage

// File: rtl/dseq_prech.sv
module dseq_prech
  import dseq_pkg::*;
#(
  parameter int PRE_SHORT = 3,
  parameter int PRE_LONG  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_rise,
  input  logic ras_n,
  input  logic prech_n,
  output logic prech_ok
);
  localparam int CW = $clog2(PRE_LONG + 1);
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] hi_cnt;
  logic [CW-1:0] need;

  // Counts rising edges seen with RAS high; saturates.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= SAT;
    end else if (ras_rise) begin
      hi_cnt <= CW'(1);
    end else if (ras_n && (hi_cnt != SAT)) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assign need     = CW'(prech_need(prech_n, PRE_SHORT, PRE_LONG));
  assign prech_ok = (hi_cnt >= need);

endmodule

// File: rtl/dseq_half.sv
module dseq_half (
  input  logic clk,
  input  logic rst,
  input  logic idle_ok,
  input  logic refresh_req,
  input  logic in_acc,
  input  logic hold_n,
  input  logic cas_arm,
  output logic ref_take,
  output logic col_half,
  output logic cas_n
);
  // Falling-edge stage: refresh sampling, half-cycle row hold, CAS.
  always_ff @(negedge clk) begin
    if (rst) begin
      ref_take <= 1'b0;
      col_half <= 1'b0;
      cas_n    <= 1'b1;
    end else begin
      ref_take <= idle_ok & refresh_req;
      col_half <= in_acc & hold_n;
      cas_n    <= ~cas_arm;
    end
  end

endmodule

// File: rtl/dseq_fsm.sv
module dseq_fsm
  import dseq_pkg::*;
#(
  parameter int RAS_LEN = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    req_n,
  input  logic    page_n,
  input  logic    prech_ok,
  input  logic    ref_take,
  output seq_st_e state,
  output logic    ras_n,
  output logic    grant,
  output logic    ack_n,
  output logic    cas_arm,
  output logic    col_full,
  output logic    refresh_done,
  output logic    ras_rise
);
  localparam int TW = $clog2(RAS_LEN + 1);

  logic [TW-1:0] tcnt, tcnt_d;
  seq_st_e       st_d;
  logic          ras_d, gnt_d, ack_d, arm_d, col_d, done_d;
  logic          ras_end;

  function automatic logic [TW-1:0] tick(input logic [TW-1:0] t);
    return (t == TW'(RAS_LEN)) ? t : t + 1'b1;
  endfunction

  assign ras_end = (tcnt == TW'(RAS_LEN));

  always_comb begin
    st_d     = state;
    ras_d    = ras_n;
    gnt_d    = grant;
    ack_d    = ack_n;
    arm_d    = cas_arm;
    col_d    = col_full;
    done_d   = 1'b0;
    ras_rise = 1'b0;
    tcnt_d   = tick(tcnt);
    unique case (state)
      ST_IDLE: begin
        tcnt_d = '0;
        if (ref_take) begin
          st_d   = ST_REF;
          ras_d  = 1'b0;
          tcnt_d = TW'(1);
        end else if (prech_ok && !req_n) begin
          st_d   = ST_ACC;
          ras_d  = 1'b0;
          gnt_d  = 1'b1;
          tcnt_d = TW'(1);
        end
      end
      ST_ACC: begin
        if ((tcnt == TW'(1)) && !req_n) begin
          arm_d = 1'b1;
          col_d = 1'b1;
        end
        if (req_n) begin
          gnt_d = 1'b0;
          arm_d = 1'b0;
          ack_d = 1'b1;
        end
        if (ras_end) begin
          if (!req_n) ack_d = 1'b0;
          if (page_n || req_n) begin
            ras_d    = 1'b1;
            ras_rise = 1'b1;
            if (req_n) begin
              st_d  = ST_IDLE;
              col_d = 1'b0;
            end else begin
              st_d = ST_HOLD;
            end
          end
        end
      end
      ST_HOLD: begin
        if (req_n) begin
          gnt_d = 1'b0;
          arm_d = 1'b0;
          ack_d = 1'b1;
          col_d = 1'b0;
          st_d  = ST_IDLE;
        end
      end
      ST_REF: begin
        if (ras_end) begin
          ras_d    = 1'b1;
          ras_rise = 1'b1;
          done_d   = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      ras_n        <= 1'b1;
      grant        <= 1'b0;
      ack_n        <= 1'b1;
      cas_arm      <= 1'b0;
      col_full     <= 1'b0;
      refresh_done <= 1'b0;
      tcnt         <= '0;
    end else begin
      state        <= st_d;
      ras_n        <= ras_d;
      grant        <= gnt_d;
      ack_n        <= ack_d;
      cas_arm      <= arm_d;
      col_full     <= col_d;
      refresh_done <= done_d;
      tcnt         <= tcnt_d;
    end
  end

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dseq_pkg::*;
#(
  parameter int RAS_LEN   = 4,
  parameter int PRE_SHORT = 3,
  parameter int PRE_LONG  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_n,
  input  logic       page_n,
  input  logic       prech_n,
  input  logic       hold_n,
  input  logic       refresh_req,
  output logic       ras_n,
  output logic       cas_n,
  output logic       grant,
  output logic       ack_n,
  output logic       ack_oe,
  output logic [1:0] addr_sel,
  output logic       refresh_done
);
  seq_st_e   state;
  addr_sel_e sel;
  logic      prech_ok, ref_take, ras_rise, cas_arm, col_full, col_half;
  logic      idle_ok, in_acc;

  assign idle_ok = (state == ST_IDLE) && prech_ok;
  assign in_acc  = (state == ST_ACC) || (state == ST_HOLD);

  dseq_prech #(
    .PRE_SHORT(PRE_SHORT),
    .PRE_LONG (PRE_LONG)
  ) u_prech (
    .clk     (clk),
    .rst     (rst),
    .ras_rise(ras_rise),
    .ras_n   (ras_n),
    .prech_n (prech_n),
    .prech_ok(prech_ok)
  );

  dseq_fsm #(
    .RAS_LEN(RAS_LEN)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_n       (req_n),
    .page_n      (page_n),
    .prech_ok    (prech_ok),
    .ref_take    (ref_take),
    .state       (state),
    .ras_n       (ras_n),
    .grant       (grant),
    .ack_n       (ack_n),
    .cas_arm     (cas_arm),
    .col_full    (col_full),
    .refresh_done(refresh_done),
    .ras_rise    (ras_rise)
  );

  dseq_half u_half (
    .clk        (clk),
    .rst        (rst),
    .idle_ok    (idle_ok),
    .refresh_req(refresh_req),
    .in_acc     (in_acc),
    .hold_n     (hold_n),
    .cas_arm    (cas_arm),
    .ref_take   (ref_take),
    .col_half   (col_half),
    .cas_n      (cas_n)
  );

  always_comb begin
    if (ref_take || (state == ST_REF)) sel = SEL_REF;
    else if (in_acc && (col_full || col_half)) sel = SEL_COL;
    else sel = SEL_ROW;
  end

  assign addr_sel = sel;
  assign ack_oe   = ~req_n;

endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
  parameter int PRE_SHORT = 3,
  parameter int PRE_LONG  = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       prech_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       grant,
  input logic       ack_n,
  input logic [1:0] addr_sel,
  input logic       refresh_done
);
  logic [7:0] hi_run;
  logic [7:0] need_hi;

  always_ff @(posedge clk) begin
    if (rst) hi_run <= 8'hFF;
    else if (!ras_n) hi_run <= 8'd0;
    else if (hi_run != 8'hFF) hi_run <= hi_run + 8'd1;
  end

  assign need_hi = prech_n ? 8'(PRE_SHORT) : 8'(PRE_LONG);

  AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (hi_run >= need_hi)); // R3
  AST_GRANT_WITH_RAS: assert property (@(posedge clk) disable iff (rst)
    $rose(grant) |-> !ras_n); // R2
  AST_REFRESH_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (addr_sel == 2'd2) |-> !grant); // R4
  AST_DONE_AT_RAS_RISE: assert property (@(posedge clk) disable iff (rst)
    refresh_done |-> (ras_n && $past(!ras_n))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    refresh_done |=> !refresh_done); // R5
  AST_CAS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(grant) |=> cas_n); // R7
  AST_ACK_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    !ack_n |-> grant); // R9

endmodule

bind dram_seq dseq_chk #(
  .PRE_SHORT(PRE_SHORT),
  .PRE_LONG (PRE_LONG)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .prech_n     (prech_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .grant       (grant),
  .ack_n       (ack_n),
  .addr_sel    (addr_sel),
  .refresh_done(refresh_done)
);

// File: tb/sim_dram_seq.sv
module sim_dram_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_n = 1'b1, page_n = 1'b1, prech_n = 1'b1, hold_n = 1'b1;
  logic refresh_req = 1'b0;
  logic ras_n, cas_n, grant, ack_n, ack_oe, refresh_done;
  logic [1:0] addr_sel;

  always #5 clk = ~clk;

  dram_seq u0 (
    .clk(clk), .rst(rst), .req_n(req_n), .page_n(page_n), .prech_n(prech_n),
    .hold_n(hold_n), .refresh_req(refresh_req), .ras_n(ras_n), .cas_n(cas_n),
    .grant(grant), .ack_n(ack_n), .ack_oe(ack_oe), .addr_sel(addr_sel),
    .refresh_done(refresh_done)
  );

  int vecs = 0, errs = 0, pending = 0, h = 0;
  string scen = "R1";
  bit run = 0, done_flag = 0;

  // Reference model state: kind 0 idle, 1 access, 2 refresh, 3 access held.
  int kind = 0, low_h = 0, hi_h = -1000;
  bit e_ras_n = 1, e_gnt = 0, e_ack_n = 1, e_done = 0, e_cas_n = 1;
  bit cas_on = 0, col_on = 0, half_on = 0, ref_won = 0;

  function automatic int need_c(input logic p);
    return (p === 1'b1) ? 3 : 4;
  endfunction

  function automatic int exp_sel();
    if (ref_won || kind == 2) return 2;
    if ((kind == 1 || kind == 3) && (col_on || half_on)) return 1;
    return 0;
  endfunction

  task automatic chk(input string rq, input string sig, input int got, input int exp);
    vecs++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s [%s] %s at %0t: got %0d expected %0d", rq, scen, sig, $time, got, exp);
    end
  endtask

  task automatic compare_all();
    chk("R8", "ras_n", int'(ras_n), int'(e_ras_n));
    chk("R2", "grant", int'(grant), int'(e_gnt));
    chk("R7", "cas_n", int'(cas_n), int'(e_cas_n));
    chk("R9", "ack_n", int'(ack_n), int'(e_ack_n));
    chk("R9", "ack_oe", int'(ack_oe), int'(!req_n));
    chk("R6", "addr_sel", int'(addr_sel), exp_sel());
    chk("R5", "refresh_done", int'(refresh_done), int'(e_done));
  endtask

  // Rising-edge half of the reference model.
  always @(posedge clk) begin
    int age;
    h = h + 1;
    if (rst) begin
      kind = 0; hi_h = -1000; e_ras_n = 1; e_gnt = 0; e_ack_n = 1;
      e_done = 0; cas_on = 0; col_on = 0;
    end else begin
      e_done = 0;
      age = (h - low_h) / 2;
      case (kind)
        0: begin
          if (ref_won) begin
            kind = 2; low_h = h; e_ras_n = 0;
          end else if (!req_n && ((h - hi_h) / 2 >= need_c(prech_n))) begin
            kind = 1; low_h = h; e_ras_n = 0; e_gnt = 1;
          end
        end
        1: begin
          if (age == 1 && !req_n) begin cas_on = 1; col_on = 1; end
          if (req_n) begin e_gnt = 0; cas_on = 0; e_ack_n = 1; end
          if (age >= 4 && !req_n) e_ack_n = 0;
          if (age >= 4 && (page_n || req_n)) begin
            e_ras_n = 1; hi_h = h;
            if (req_n) begin kind = 0; col_on = 0; end
            else kind = 3;
          end
        end
        3: begin
          if (req_n) begin e_gnt = 0; cas_on = 0; e_ack_n = 1; col_on = 0; kind = 0; end
        end
        2: begin
          if (age == 4) begin e_ras_n = 1; hi_h = h; e_done = 1; kind = 0; end
        end
        default: kind = 0;
      endcase
    end
    #3;
    if (run) compare_all();
  end

  // Falling-edge half of the reference model.
  always @(negedge clk) begin
    h = h + 1;
    if (rst) begin
      ref_won = 0; e_cas_n = 1; half_on = 0; run = 1;
    end else begin
      ref_won = (kind == 0) && (refresh_req === 1'b1) && ((h + 1 - hi_h) / 2 >= need_c(prech_n));
      e_cas_n = !cas_on;
      half_on = (kind == 1 || kind == 3) && (hold_n === 1'b1);
    end
    #3;
    if (run) compare_all();
  end

  // Emulated refresh backlog: one pending refresh retired per done pulse.
  always @(posedge clk) begin
    #1;
    if (refresh_done === 1'b1 && pending > 0) pending = pending - 1;
    refresh_req = (pending > 0);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errs++;
    $display("FAIL R1 watchdog: got still running expected finished");
    finish_run();
  end

  initial begin
    step(3);
    // R1: reset state at the ports
    chk("R1", "reset ras_n", int'(ras_n), 1);
    chk("R1", "reset cas_n", int'(cas_n), 1);
    chk("R1", "reset grant", int'(grant), 0);
    chk("R1", "reset ack_n", int'(ack_n), 1);
    chk("R1", "reset addr_sel", int'(addr_sel), 0);
    chk("R1", "reset refresh_done", int'(refresh_done), 0);
    rst = 0;
    // R1: immediate access right after reset; R2/R6 half-cycle hold
    scen = "R2";
    req_n = 0; step(8); req_n = 1; step(6);
    // R6: full-cycle row hold, then back-to-back with 3-cycle precharge
    scen = "R6";
    hold_n = 0; req_n = 0; step(7); req_n = 1; step(1); req_n = 0; step(7); req_n = 1; step(5);
    hold_n = 1;
    // R3: 4-cycle precharge between back-to-back accesses
    scen = "R3";
    prech_n = 0; step(1);
    req_n = 0; step(6); req_n = 1; step(1); req_n = 0; step(7); req_n = 1; step(6);
    prech_n = 1;
    // R8: page mode ended by page_n, then by req_n
    scen = "R8";
    page_n = 0; req_n = 0; step(9); page_n = 1; step(3); req_n = 1; step(5);
    page_n = 0; req_n = 0; step(7); req_n = 1; step(1); page_n = 1; step(5);
    // R5: refresh bursts ignore page_n
    scen = "R5";
    page_n = 0; pending = pending + 2; step(20); page_n = 1; step(3);
    // R4: simultaneous requests, and a refresh arriving during precharge
    scen = "R4";
    req_n = 0; pending = pending + 1; step(14); req_n = 1; step(4);
    req_n = 0; step(6); req_n = 1; step(1); pending = pending + 1; req_n = 0; step(14);
    req_n = 1; step(6);
    // R10: long hold, then refresh backlog drained after a long page access
    scen = "R10";
    req_n = 0; step(15); req_n = 1; step(5);
    page_n = 0; req_n = 0; step(2); pending = pending + 3; step(15);
    req_n = 1; page_n = 1; step(40);
    // R9: request released early, before the acknowledge point
    scen = "R9";
    req_n = 0; step(2); req_n = 1; step(8);
    prech_n = 0; req_n = 0; step(1); req_n = 1; step(8);
    step(5);
    finish_run();
  end

endmodule